// File: doc/BRIEF.md
# Serial Receive Queue with Line Status

This block turns an asynchronous serial line into characters. It samples the line on a 16x oversampling tick and applies a frame format set at its inputs: 5 to 8 data bits, an optional parity bit of one of four kinds, and one or two stop bits. Each character goes into a 16-entry queue. Every entry carries its own parity, framing and break flags, so the error flags always describe the character waiting at the read port.

The surrounding logic reads characters with a one-cycle read strobe. It watches data-ready and a fill-level trigger, and it clears the sticky overrun flag with a status-read strobe. The queue can be emptied on request. When the queue is disabled, it acts as a single holding register.

Top module: `serial_rx_queue`

## Requirements
- R1: Word length code `wlen_i` 0, 1, 2, 3 selects 5, 6, 7, 8 data bits. Bits arrive least significant first. Data bits above the word length read as 0.
- R2: When `par_en_i` is 1, one parity bit follows the data. `par_type_i` 0 requires an odd count of ones over data plus parity, 1 an even count, 2 a parity bit of 1 and 3 a parity bit of 0. A mismatch sets the entry's parity flag. When `par_en_i` is 0 the flag is 0.
- R3: `stop2_i` selects two stop bits instead of one. The framing flag is set if any sampled stop bit is 0. After such a character, the receiver waits for the line to go high before it looks for a new start bit.
- R4: A character whose start, data, parity and stop samples are all low is stored once, as data 0 with the break and framing flags set.
- R5: A falling edge counts as a start bit only if the line is still low 8 ticks later. A shorter low pulse stores nothing.
- R6: Characters leave the queue in arrival order through `rd_data_o`. `data_ready_o` is 1 exactly while the queue is not empty. `rd_i` removes the head entry, and `rd_i` on an empty queue has no effect.
- R7: A character that completes while the queue holds its full capacity is discarded and sets `overrun_o`. The stored entries are kept. `overrun_o` stays set until `stat_rd_i` is pulsed.
- R8: `trig_o` is 1 while the fill level is at least 1, 4, 8 or 14 for `trig_sel_i` 0, 1, 2 or 3.
- R9: `fifo_err_o` is 1 while any stored entry has its parity, framing or break flag set.
- R10: A pulse on `fifo_rst_i` empties the queue.
- R11: With `fifo_en_i` at 0 the capacity is one character. Any change of `fifo_en_i` empties the queue.
- R12: `parity_err_o`, `framing_err_o` and `break_o` show the flags of the head entry, and are 0 while the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial line, idle high |
| tick_i | input | 1 | 16x oversampling tick, one cycle wide |
| wlen_i | input | 2 | Word length code |
| stop2_i | input | 1 | Two stop bits when 1 |
| par_en_i | input | 1 | Parity bit present |
| par_type_i | input | 2 | Parity kind |
| fifo_en_i | input | 1 | Queue enabled (0: single entry) |
| fifo_rst_i | input | 1 | Empty the queue |
| trig_sel_i | input | 2 | Trigger level code |
| rd_i | input | 1 | Read strobe, pops the head entry |
| stat_rd_i | input | 1 | Status read strobe, clears overrun |
| rd_data_o | output | 8 | Head entry data |
| data_ready_o | output | 1 | Queue not empty |
| overrun_o | output | 1 | Sticky overrun |
| parity_err_o | output | 1 | Head entry parity flag |
| framing_err_o | output | 1 | Head entry framing flag |
| break_o | output | 1 | Head entry break flag |
| fifo_err_o | output | 1 | Some stored entry has an error |
| trig_o | output | 1 | Fill level reached |

## Verification
The assertions check on every cycle that the status outputs agree with each other. The head-entry flags stay low and the trigger and error summary are off whenever the queue is empty. A break always carries a framing flag. The fill level never goes above capacity, and it stays at or below one while the queue is disabled. Overrun can only rise when data is already stored. Only the bench's frame scenarios can show the rest: correct deserialisation for each word length and parity kind, stop-bit framing, rejection of start glitches, arrival order across a full queue, the dropped character on overrun, and the exact fill counts at which each trigger level switches.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef struct packed {
    logic [7:0] data;
    logic       perr;
    logic       ferr;
    logic       brk;
  } rx_entry_t;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_WAIT_HI
  } rx_state_e;

  function automatic logic [7:0] trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return 8'd1;
      2'd1:    return 8'd4;
      2'd2:    return 8'd8;
      default: return 8'd14;
    endcase
  endfunction
endpackage

// File: rtl/rxq_deser.sv
module rxq_deser
  import rxq_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_i,
  input  logic       tick_i,
  input  logic [1:0] wlen_i,
  input  logic       stop2_i,
  input  logic       par_en_i,
  input  logic [1:0] par_type_i,
  output logic       push_o,
  output rx_entry_t  entry_o
);
  localparam int TW = $clog2(OVS);
  localparam logic [TW-1:0] MID  = TW'(OVS/2 - 1);
  localparam logic [TW-1:0] LAST = TW'(OVS - 1);

  logic [1:0]    sync_q;
  logic          rx_s;
  rx_state_e     st_q;
  logic [TW-1:0] tcnt_q;
  logic [2:0]    bcnt_q;
  logic [7:0]    sh_q;
  logic          par_q, low_q, sbad_q, sidx_q;
  logic [2:0]    last_idx;
  logic          at_last, final_stop, bad_now;
  logic [7:0]    data_al;
  logic          x;

  // two-flop synchroniser on the line
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rx_i};
  end
  assign rx_s = sync_q[1];

  assign last_idx   = 3'd4 + {1'b0, wlen_i};
  assign at_last    = tick_i && (tcnt_q == LAST);
  assign final_stop = (st_q == S_STOP) && (sidx_q == stop2_i);
  assign bad_now    = sbad_q | ~rx_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      tcnt_q <= '0;
      bcnt_q <= '0;
      sh_q   <= '0;
      par_q  <= 1'b0;
      low_q  <= 1'b0;
      sbad_q <= 1'b0;
      sidx_q <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: if (tick_i && !rx_s) begin
          st_q   <= S_START;
          tcnt_q <= '0;
        end
        S_START: if (tick_i) begin
          if (tcnt_q == MID) begin
            tcnt_q <= '0;
            if (!rx_s) begin
              st_q   <= S_DATA;
              bcnt_q <= '0;
              sh_q   <= '0;
              par_q  <= 1'b0;
              low_q  <= 1'b1;
              sbad_q <= 1'b0;
              sidx_q <= 1'b0;
            end else begin
              st_q <= S_IDLE;
            end
          end else begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
        S_DATA, S_PAR, S_STOP: if (tick_i) begin
          if (at_last) begin
            tcnt_q <= '0;
            low_q  <= low_q & ~rx_s;
            if (st_q == S_DATA) begin
              sh_q <= {rx_s, sh_q[7:1]};
              if (bcnt_q == last_idx) st_q <= par_en_i ? S_PAR : S_STOP;
              else                    bcnt_q <= bcnt_q + 1'b1;
            end else if (st_q == S_PAR) begin
              par_q <= rx_s;
              st_q  <= S_STOP;
            end else if (final_stop) begin
              st_q <= bad_now ? S_WAIT_HI : S_IDLE;
            end else begin
              sidx_q <= 1'b1;
              sbad_q <= bad_now;
            end
          end else begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
        S_WAIT_HI: if (rx_s) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign data_al = sh_q >> (2'd3 - wlen_i);
  assign x       = (^data_al) ^ par_q;

  always_comb begin
    entry_o.data = data_al;
    entry_o.ferr = bad_now;
    entry_o.brk  = low_q & ~rx_s;
    case (par_type_i)
      2'd0:    entry_o.perr = par_en_i & ~x;
      2'd1:    entry_o.perr = par_en_i & x;
      2'd2:    entry_o.perr = par_en_i & ~par_q;
      default: entry_o.perr = par_en_i & par_q;
    endcase
  end

  assign push_o = at_last && final_stop;
endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  rx_entry_t     entry_i,
  input  logic          pop_i,
  input  logic          flush_i,
  input  logic          single_i,
  output rx_entry_t     head_o,
  output logic [CW-1:0] fill_o,
  output logic          drop_o,
  output logic          any_err_o
);
  rx_entry_t     mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] fill_q, errs_q, cap;
  logic          full, do_push, do_pop, in_err, out_err;

  assign cap     = single_i ? CW'(1) : CW'(DEPTH);
  assign full    = fill_q >= cap;
  assign do_push = push_i && !full && !flush_i;
  assign do_pop  = pop_i && (fill_q != '0) && !flush_i;
  assign head_o  = mem_q[rp_q];
  assign in_err  = entry_i.perr | entry_i.ferr | entry_i.brk;
  assign out_err = head_o.perr | head_o.ferr | head_o.brk;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= entry_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q   <= '0;
      rp_q   <= '0;
      fill_q <= '0;
      errs_q <= '0;
    end else if (flush_i) begin
      wp_q   <= '0;
      rp_q   <= '0;
      fill_q <= '0;
      errs_q <= '0;
    end else begin
      if (do_push) wp_q <= wp_q + 1'b1;
      if (do_pop)  rp_q <= rp_q + 1'b1;
      fill_q <= fill_q + CW'(do_push) - CW'(do_pop);
      errs_q <= errs_q + CW'(do_push && in_err) - CW'(do_pop && out_err);
    end
  end

  assign fill_o    = fill_q;
  assign drop_o    = push_i && full && !flush_i;
  assign any_err_o = errs_q != '0;
endmodule

// File: rtl/rxq_lsr.sv
module rxq_lsr
  import rxq_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          drop_i,
  input  logic          stat_rd_i,
  input  logic [CW-1:0] fill_i,
  input  logic [1:0]    trig_sel_i,
  output logic          overrun_o,
  output logic          trig_o
);
  // a drop in the same cycle as a status read wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        overrun_o <= 1'b0;
    else if (drop_i)    overrun_o <= 1'b1;
    else if (stat_rd_i) overrun_o <= 1'b0;
  end

  assign trig_o = fill_i >= CW'(trig_level(trig_sel_i));
endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int OVS   = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_i,
  input  logic       tick_i,
  input  logic [1:0] wlen_i,
  input  logic       stop2_i,
  input  logic       par_en_i,
  input  logic [1:0] par_type_i,
  input  logic       fifo_en_i,
  input  logic       fifo_rst_i,
  input  logic [1:0] trig_sel_i,
  input  logic       rd_i,
  input  logic       stat_rd_i,
  output logic [7:0] rd_data_o,
  output logic       data_ready_o,
  output logic       overrun_o,
  output logic       parity_err_o,
  output logic       framing_err_o,
  output logic       break_o,
  output logic       fifo_err_o,
  output logic       trig_o
);
  localparam int CW = $clog2(DEPTH + 1);

  rx_entry_t     rx_entry, head;
  logic          push, drop, flush, en_q;
  logic [CW-1:0] fill;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b1;
    else         en_q <= fifo_en_i;
  end
  assign flush = fifo_rst_i | (fifo_en_i ^ en_q);

  rxq_deser #(.OVS(OVS)) i_deser (
    .clk_i, .rst_ni, .rx_i, .tick_i, .wlen_i, .stop2_i, .par_en_i, .par_type_i,
    .push_o(push), .entry_o(rx_entry)
  );

  rxq_fifo #(.DEPTH(DEPTH)) i_fifo (
    .clk_i, .rst_ni, .push_i(push), .entry_i(rx_entry), .pop_i(rd_i),
    .flush_i(flush), .single_i(~fifo_en_i), .head_o(head), .fill_o(fill),
    .drop_o(drop), .any_err_o(fifo_err_o)
  );

  rxq_lsr #(.CW(CW)) i_lsr (
    .clk_i, .rst_ni, .drop_i(drop), .stat_rd_i, .fill_i(fill),
    .trig_sel_i, .overrun_o, .trig_o
  );

  assign data_ready_o  = fill != '0;
  assign rd_data_o     = data_ready_o ? head.data : 8'h00;
  assign parity_err_o  = data_ready_o & head.perr;
  assign framing_err_o = data_ready_o & head.ferr;
  assign break_o       = data_ready_o & head.brk;
endmodule

// File: rtl/serial_rx_queue_chk.sv
module serial_rx_queue_chk #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          fifo_en_i,
  input logic          fifo_rst_i,
  input logic          data_ready_o,
  input logic          overrun_o,
  input logic          parity_err_o,
  input logic          framing_err_o,
  input logic          break_o,
  input logic          fifo_err_o,
  input logic          trig_o,
  input logic [CW-1:0] fill_i
);
  AST_FLAGS_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_ready_o |-> !(parity_err_o || framing_err_o || break_o)); // R12
  AST_BRK_FRAMING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    break_o |-> framing_err_o); // R4
  AST_TRIG_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> data_ready_o); // R8
  AST_ERRSUM_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_err_o |-> data_ready_o); // R9
  AST_RST_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rst_i |=> !data_ready_o); // R10
  AST_FILL_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i <= CW'(DEPTH)); // R6
  AST_SINGLE_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_en_i && !$past(fifo_en_i)) |-> fill_i <= CW'(1)); // R11
  AST_OVR_NEEDS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> $past(data_ready_o)); // R7
endmodule

bind serial_rx_queue serial_rx_queue_chk #(.DEPTH(DEPTH)) i_chk (
  .clk_i, .rst_ni, .fifo_en_i, .fifo_rst_i, .data_ready_o, .overrun_o,
  .parity_err_o, .framing_err_o, .break_o, .fifo_err_o, .trig_o, .fill_i(fill)
);

// File: tb/test_serial_rx_queue.sv
module test_serial_rx_queue;
  localparam int TDIV = 4;
  localparam int BIT_CLK = 16 * TDIV;
  localparam int NV = 9;
  // {wlen, pen, ptype, stop2, data, badpar, badstop, exp_data, exp_perr, exp_ferr}
  localparam logic [25:0] VEC [NV] = '{
    {2'd3, 1'b0, 2'd0, 1'b0, 8'hA5, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0},
    {2'd0, 1'b0, 2'd0, 1'b0, 8'hFF, 1'b0, 1'b0, 8'h1F, 1'b0, 1'b0},
    {2'd1, 1'b1, 2'd0, 1'b0, 8'h2D, 1'b0, 1'b0, 8'h2D, 1'b0, 1'b0},
    {2'd2, 1'b1, 2'd1, 1'b1, 8'h55, 1'b0, 1'b0, 8'h55, 1'b0, 1'b0},
    {2'd3, 1'b1, 2'd2, 1'b0, 8'h3C, 1'b1, 1'b0, 8'h3C, 1'b1, 1'b0},
    {2'd3, 1'b1, 2'd3, 1'b0, 8'h81, 1'b0, 1'b0, 8'h81, 1'b0, 1'b0},
    {2'd3, 1'b1, 2'd1, 1'b0, 8'h7E, 1'b1, 1'b0, 8'h7E, 1'b1, 1'b0},
    {2'd3, 1'b0, 2'd0, 1'b0, 8'h42, 1'b0, 1'b1, 8'h42, 1'b0, 1'b1},
    {2'd3, 1'b0, 2'd0, 1'b1, 8'h99, 1'b0, 1'b1, 8'h99, 1'b0, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx = 1'b1, tick = 1'b0;
  logic [1:0] wlen = 2'd3, ptype = 2'd0, tsel = 2'd0;
  logic stop2 = 1'b0, pen = 1'b0, fen = 1'b1, frst = 1'b0, rd = 1'b0, srd = 1'b0;
  logic [7:0] rdata;
  logic dr, ovr, perr, ferr, brk, ferrsum, trig;
  int n_vec = 0, n_err = 0, tcnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  always @(negedge clk) begin
    tcnt <= (tcnt == TDIV - 1) ? 0 : tcnt + 1;
    tick <= (tcnt == 0);
  end

  serial_rx_queue i_serial_rx_queue (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .tick_i(tick), .wlen_i(wlen),
    .stop2_i(stop2), .par_en_i(pen), .par_type_i(ptype), .fifo_en_i(fen),
    .fifo_rst_i(frst), .trig_sel_i(tsel), .rd_i(rd), .stat_rd_i(srd),
    .rd_data_o(rdata), .data_ready_o(dr), .overrun_o(ovr), .parity_err_o(perr),
    .framing_err_o(ferr), .break_o(brk), .fifo_err_o(ferrsum), .trig_o(trig)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int bits);
    rx = v;
    repeat (bits * BIT_CLK) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic badpar, input logic badstop);
    logic [7:0] m;
    logic p;
    m = 8'hFF >> (2'd3 - wlen);
    case (ptype)
      2'd0: p = ~^(d & m);
      2'd1: p = ^(d & m);
      2'd2: p = 1'b1;
      default: p = 1'b0;
    endcase
    hold(1'b0, 1);
    for (int i = 0; i < 5 + int'(wlen); i++) hold(d[i], 1);
    if (pen) hold(p ^ badpar, 1);
    if (stop2) hold(1'b1, 1);
    hold(~badstop, 1);
    hold(1'b1, 2);
  endtask

  task automatic pulse_rd();
    rd = 1'b1; @(negedge clk); rd = 1'b0; @(negedge clk);
  endtask

  task automatic pulse_srd();
    srd = 1'b1; @(negedge clk); srd = 1'b0; @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(negedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // reset state
    check("R6 reset data_ready", dr, 0);
    check("R7 reset overrun", ovr, 0);
    check("R8 reset trig", trig, 0);
    check("R9 reset fifo_err", ferrsum, 0);

    // frame-format vectors: R1 R2 R3
    for (int v = 0; v < NV; v++) begin
      logic [25:0] e;
      e = VEC[v];
      wlen = e[25:24]; pen = e[23]; ptype = e[22:21]; stop2 = e[20];
      send(e[19:12], e[11], e[10]);
      check("R6 data_ready", dr, 1);
      check("R8 trig level 1", trig, 1);
      check("R1 data", rdata, e[9:2]);
      check("R2 parity flag", perr, e[1]);
      check("R3 framing flag", ferr, e[0]);
      check("R9 fifo_err", ferrsum, e[1] | e[0]);
      pulse_rd();
      check("R6 empty after read", dr, 0);
    end
    wlen = 2'd3; pen = 1'b0; ptype = 2'd0; stop2 = 1'b0;

    // R4 break
    hold(1'b0, 12);
    hold(1'b1, 3);
    check("R4 break flag", brk, 1);
    check("R4 break framing", ferr, 1);
    check("R4 break data", rdata, 0);
    check("R9 break err summary", ferrsum, 1);
    pulse_rd();
    check("R4 single break entry", dr, 0);

    // R5 short start glitch
    hold(1'b0, 0);
    repeat (4 * TDIV) @(negedge clk);
    hold(1'b1, 3);
    check("R5 glitch ignored", dr, 0);

    // R6 read on empty, then normal character
    pulse_rd();
    send(8'h3A, 1'b0, 1'b0);
    check("R6 data after empty read", rdata, 8'h3A);
    pulse_rd();
    check("R6 empty", dr, 0);

    // R8 trigger thresholds and R7 overrun
    tsel = 2'd1;
    for (int k = 0; k < 16; k++) begin
      send(8'h10 + 8'(k), 1'b0, 1'b0);
      if (k == 2) check("R8 sel1 at 3", trig, 0);
      if (k == 3) begin
        check("R8 sel1 at 4", trig, 1);
        tsel = 2'd2; @(negedge clk);
        check("R8 sel2 at 4", trig, 0);
      end
      if (k == 7) check("R8 sel2 at 8", trig, 1);
      if (k == 12) begin
        tsel = 2'd3; @(negedge clk);
        check("R8 sel3 at 13", trig, 0);
      end
      if (k == 13) check("R8 sel3 at 14", trig, 1);
    end
    check("R7 no overrun at full", ovr, 0);
    send(8'hEE, 1'b0, 1'b0);
    check("R7 overrun set", ovr, 1);
    for (int k = 0; k < 16; k++) begin
      check("R6 R7 order kept", rdata, 8'h10 + 8'(k));
      pulse_rd();
    end
    check("R7 new char dropped", dr, 0);
    check("R7 overrun sticky", ovr, 1);
    pulse_srd();
    check("R7 overrun cleared", ovr, 0);
    tsel = 2'd0;

    // R9 R12 per-entry flags
    send(8'h11, 1'b0, 1'b0);
    pen = 1'b1; ptype = 2'd1;
    send(8'h22, 1'b1, 1'b0);
    pen = 1'b0;
    send(8'h33, 1'b0, 1'b0);
    check("R9 err summary set", ferrsum, 1);
    check("R12 head clean", perr, 0);
    pulse_rd();
    check("R12 head parity", perr, 1);
    check("R12 head data", rdata, 8'h22);
    pulse_rd();
    check("R9 err summary clear", ferrsum, 0);
    check("R12 head clean again", perr, 0);

    // R10 queue reset
    send(8'h44, 1'b0, 1'b0);
    check("R10 before reset", dr, 1);
    frst = 1'b1; @(negedge clk); frst = 1'b0; @(negedge clk);
    check("R10 emptied", dr, 0);
    check("R10 trig", trig, 0);

    // R11 single holding register
    fen = 1'b0; repeat (2) @(negedge clk);
    send(8'h5A, 1'b0, 1'b0);
    send(8'hC3, 1'b0, 1'b0);
    check("R11 overrun at one", ovr, 1);
    check("R11 first kept", rdata, 8'h5A);
    pulse_rd();
    check("R11 single entry", dr, 0);
    pulse_srd();
    fen = 1'b1; repeat (2) @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule